// File: doc/BRIEF.md
# Flash Target Programming-Mode Responder

This block models the device side of a byte-wide parallel programming port. An external programmer drives a five-line mode code, a 12-bit address, a data byte, a program strobe, a high-voltage enable and two qualifying lines. The block decodes these pins and either answers a read or starts a write. Reads return code bytes, the lock bits or fixed signature bytes. Writes are byte programming, three lock-bit writes and a whole-array erase.

Each write runs on its own internal timer, counted in cycles of the block clock. The ready/busy output stays low while the timer runs, and strobes that arrive during that time are dropped. A code read of the byte being written returns that byte with its top bit inverted. The programmer can poll on this marked value to find out when the write has finished.

The code array holds 4096 bytes. The lock register holds three bits.

Top module: `flashprog_resp`

## Requirements
- R1: After `rst_n` is released, `wr_idle` is 1, `dout_en` is 0 and all three lock bits are 0.
- R2: The mode code is `sel[4:0]`, written MSB first: code read 5'b00011, byte write 5'b01111, lock-1 write 5'b11111, lock-2 write 5'b11100, lock-3 write 5'b10110, lock read 5'b11010, erase 5'b10100, signature read 5'b00000. Every other code does nothing.
- R3: A write starts in the clock cycle in which `wstrb_n` is seen rising while the write conditions hold. From the next cycle, `wr_idle` is 0 for exactly WRITE_CYCLES cycles. A byte write then stores (old byte AND `din`).
- R4: A strobe starts nothing unless all of these hold: `prog_mode` is 1, `fetch_n` is 0, `hv_on` is 1 and `sel` is a write code. In that case `wr_idle` stays 1 and the array is unchanged.
- R5: A strobe that rises while `wr_idle` is 0 is ignored. It neither changes the array nor lengthens the busy period.
- R6: Erase sets every byte to 0xFF and clears all lock bits. Its busy period lasts max(WRITE_CYCLES, 2^ADDR_W) cycles.
- R7: A lock write sets its own lock bit. A lock read returns lock bits 1, 2 and 3 on `dout[2]`, `dout[3]` and `dout[4]`, with every other bit 0.
- R8: A signature read returns 0x1E at address 0x000, 0x51 at 0x100 and 0x06 at 0x200. All other addresses return 0x00.
- R9: During a byte write, a code read of the address being written returns `din` with bit 7 inverted. Code reads of other addresses return the stored bytes.
- R10: `dout_en` is 1 only under all of these: a read code is selected, `prog_mode` is 1, `fetch_n` is 0, `wstrb_n` is 1 and `hv_on` is 0. Whenever `dout_en` is 0, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that times the writes |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_mode | input | 1 | High selects programming mode |
| fetch_n | input | 1 | Must be low for any access |
| wstrb_n | input | 1 | Active-low program strobe; the write is taken on its rising edge |
| hv_on | input | 1 | High-voltage enable; high for writes, low for reads |
| sel | input | 5 | Mode code |
| addr | input | 12 | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Drive enable for `dout` |
| wr_idle | output | 1 | Ready/busy: low while a write runs |

## Verification
Two functions meet in the last busy cycle of a byte write. In that cycle the timer commits the ANDed byte, and a polling read of the same address is being served. The bench switches to code-read mode right after the strobe and reads the target address every cycle. It expects the inverted-top-bit value through the final busy cycle and the committed value in the first cycle where `wr_idle` is high. A second strobe is also placed inside a busy window. The bench then checks that the busy length is unchanged and that the second address still reads 0xFF.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BYTE,
        OP_LOCK1,
        OP_LOCK2,
        OP_LOCK3,
        OP_ERASE
    } wr_op_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_CODE,
        RD_LOCK,
        RD_SIG
    } rd_op_e;

    // mode codes, sel[4:0] written MSB first
    localparam logic [4:0] MC_CODE_RD = 5'b00011;
    localparam logic [4:0] MC_BYTE_WR = 5'b01111;
    localparam logic [4:0] MC_LOCK1   = 5'b11111;
    localparam logic [4:0] MC_LOCK2   = 5'b11100;
    localparam logic [4:0] MC_LOCK3   = 5'b10110;
    localparam logic [4:0] MC_LOCK_RD = 5'b11010;
    localparam logic [4:0] MC_ERASE   = 5'b10100;
    localparam logic [4:0] MC_SIG     = 5'b00000;

    localparam int SIG_COUNT = 3;

    function automatic logic [7:0] sig_byte(input int idx);
        case (idx)
            0:       return 8'h1E;
            1:       return 8'h51;
            2:       return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/flashprog_decode.sv
module flashprog_decode
    import flashprog_pkg::*;
(
    input  logic [4:0] sel,
    output wr_op_e     wr_op,
    output rd_op_e     rd_op
);

    always_comb begin
        wr_op = OP_NONE;
        rd_op = RD_NONE;
        case (sel)
            MC_BYTE_WR: wr_op = OP_BYTE;
            MC_LOCK1:   wr_op = OP_LOCK1;
            MC_LOCK2:   wr_op = OP_LOCK2;
            MC_LOCK3:   wr_op = OP_LOCK3;
            MC_ERASE:   wr_op = OP_ERASE;
            MC_CODE_RD: rd_op = RD_CODE;
            MC_LOCK_RD: rd_op = RD_LOCK;
            MC_SIG:     rd_op = RD_SIG;
            default: begin
                wr_op = OP_NONE;
                rd_op = RD_NONE;
            end
        endcase
    end

endmodule

// File: rtl/flashprog_array.sv
module flashprog_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/flashprog_seq.sv
module flashprog_seq
    import flashprog_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              fetch_n,
    input  logic              wstrb_n,
    input  logic              hv_on,
    input  wr_op_e            wr_op_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [7:0]        old_byte,
    output logic              busy,
    output wr_op_e            cur_op,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [7:0]        cap_data,
    output logic [2:0]        lock_bits,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ERASE_LEN = (WRITE_CYCLES > DEPTH) ? WRITE_CYCLES : DEPTH;
    localparam int TW        = $clog2(ERASE_LEN + 1);
    localparam logic [TW-1:0] WR_LOAD = TW'(WRITE_CYCLES - 1);
    localparam logic [TW-1:0] ER_LOAD = TW'(ERASE_LEN - 1);

    typedef struct packed {
        logic              strb;
        logic              busy;
        wr_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [TW-1:0]     timer;
        logic [ADDR_W:0]   sweep;
        logic [2:0]        lock;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    strb_rise;
    logic    start_ok;

    always_comb begin
        st_d      = st_q;
        st_d.strb = wstrb_n;
        strb_rise = wstrb_n & ~st_q.strb;
        start_ok  = prog_mode & ~fetch_n & hv_on & (wr_op_in != OP_NONE);
        mem_we    = 1'b0;
        mem_waddr = st_q.addr;
        mem_wdata = 8'hFF;

        if (st_q.busy) begin
            // erase sweeps one byte per cycle until all addresses are done
            if (st_q.op == OP_ERASE && !st_q.sweep[ADDR_W]) begin
                mem_we     = 1'b1;
                mem_waddr  = st_q.sweep[ADDR_W-1:0];
                mem_wdata  = 8'hFF;
                st_d.sweep = st_q.sweep + 1'b1;
            end
            if (st_q.timer == '0) begin
                st_d.busy = 1'b0;
                case (st_q.op)
                    OP_BYTE: begin
                        mem_we    = 1'b1;
                        mem_waddr = st_q.addr;
                        mem_wdata = old_byte & st_q.data;
                    end
                    OP_LOCK1: st_d.lock[0] = 1'b1;
                    OP_LOCK2: st_d.lock[1] = 1'b1;
                    OP_LOCK3: st_d.lock[2] = 1'b1;
                    OP_ERASE: st_d.lock    = 3'b000;
                    default:  st_d.lock    = st_q.lock;
                endcase
            end else begin
                st_d.timer = st_q.timer - 1'b1;
            end
        end else if (strb_rise && start_ok) begin
            st_d.busy  = 1'b1;
            st_d.op    = wr_op_in;
            st_d.addr  = addr;
            st_d.data  = din;
            st_d.timer = (wr_op_in == OP_ERASE) ? ER_LOAD : WR_LOAD;
            st_d.sweep = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.strb  <= 1'b1;
            st_q.busy  <= 1'b0;
            st_q.op    <= OP_NONE;
            st_q.addr  <= '0;
            st_q.data  <= '0;
            st_q.timer <= '0;
            st_q.sweep <= '0;
            st_q.lock  <= 3'b000;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign cur_op    = st_q.op;
    assign cap_addr  = st_q.addr;
    assign cap_data  = st_q.data;
    assign lock_bits = st_q.lock;

endmodule

// File: rtl/flashprog_rdmux.sv
module flashprog_rdmux
    import flashprog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  rd_op_e            rd_op,
    input  logic              prog_mode,
    input  logic              fetch_n,
    input  logic              wstrb_n,
    input  logic              hv_on,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        arr_byte,
    input  logic              busy,
    input  wr_op_e            cur_op,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [7:0]        cap_data,
    input  logic [2:0]        lock_bits,
    output logic [7:0]        dout,
    output logic              dout_en
);

    localparam int HI_W = ADDR_W - 8;

    logic [SIG_COUNT-1:0] sig_hit;
    logic [7:0]           sig_val;
    logic                 pins_ok;
    logic                 poll_hit;

    for (genvar k = 0; k < SIG_COUNT; k++) begin : g_sig
        assign sig_hit[k] = (addr[ADDR_W-1:8] == HI_W'(k)) && (addr[7:0] == 8'h00);
    end

    always_comb begin
        sig_val = 8'h00;
        for (int k = 0; k < SIG_COUNT; k++) begin
            if (sig_hit[k]) sig_val = sig_byte(k);
        end
    end

    assign pins_ok  = prog_mode & ~fetch_n & wstrb_n & ~hv_on;
    assign poll_hit = busy && (cur_op == OP_BYTE) && (addr == cap_addr);

    always_comb begin
        dout_en = pins_ok && (rd_op != RD_NONE);
        dout    = 8'h00;
        if (dout_en) begin
            case (rd_op)
                RD_CODE: dout = poll_hit ? {~cap_data[7], cap_data[6:0]} : arr_byte;
                RD_LOCK: dout = {3'b000, lock_bits, 2'b00};
                RD_SIG:  dout = sig_val;
                default: dout = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/flashprog_resp.sv
module flashprog_resp
    import flashprog_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              fetch_n,
    input  logic              wstrb_n,
    input  logic              hv_on,
    input  logic [4:0]        sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              wr_idle
);

    wr_op_e            wr_op;
    rd_op_e            rd_op;
    logic              busy;
    wr_op_e            cur_op;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;
    logic [2:0]        lock_bits;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_byte;
    logic [7:0]        old_byte;

    flashprog_decode u_decode (
        .sel   (sel),
        .wr_op (wr_op),
        .rd_op (rd_op)
    );

    flashprog_seq #(
        .ADDR_W       (ADDR_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_mode (prog_mode),
        .fetch_n   (fetch_n),
        .wstrb_n   (wstrb_n),
        .hv_on     (hv_on),
        .wr_op_in  (wr_op),
        .addr      (addr),
        .din       (din),
        .old_byte  (old_byte),
        .busy      (busy),
        .cur_op    (cur_op),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .lock_bits (lock_bits),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    flashprog_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_array (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (addr),
        .rdata_a (rd_byte),
        .raddr_b (cap_addr),
        .rdata_b (old_byte)
    );

    flashprog_rdmux #(
        .ADDR_W (ADDR_W)
    ) u_rdmux (
        .rd_op     (rd_op),
        .prog_mode (prog_mode),
        .fetch_n   (fetch_n),
        .wstrb_n   (wstrb_n),
        .hv_on     (hv_on),
        .addr      (addr),
        .arr_byte  (rd_byte),
        .busy      (busy),
        .cur_op    (cur_op),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .lock_bits (lock_bits),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    assign wr_idle = ~busy;

endmodule

// File: rtl/flashprog_resp_chk.sv
module flashprog_resp_chk
    import flashprog_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_mode,
    input logic              fetch_n,
    input logic              wstrb_n,
    input logic              hv_on,
    input logic [4:0]        sel,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              wr_idle
);

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ERASE_LEN = (WRITE_CYCLES > DEPTH) ? WRITE_CYCLES : DEPTH;
    localparam int CW        = $clog2(ERASE_LEN + 2);

    logic          armed;
    logic [CW-1:0] busy_cnt;
    logic          wr_code;

    assign wr_code = (sel == MC_BYTE_WR) || (sel == MC_LOCK1) || (sel == MC_LOCK2) ||
                     (sel == MC_LOCK3) || (sel == MC_ERASE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            busy_cnt <= '0;
        end else begin
            armed    <= 1'b1;
            busy_cnt <= wr_idle ? '0 : busy_cnt + 1'b1;
        end
    end

    // R3: a qualified strobe rise taken while idle makes the block busy next cycle
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && wr_idle && !$past(wstrb_n) && wstrb_n && prog_mode && !fetch_n && hv_on && wr_code
        |=> !wr_idle);

    // R3/R6: no busy stretch exceeds the longest write length
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CW'(ERASE_LEN));

    // R4: without high voltage an idle block stays idle
    p_no_hv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idle && !hv_on |=> wr_idle);

    // R4: without the fetch qualifier an idle block stays idle
    p_no_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idle && fetch_n |=> wr_idle);

    // R5: busy only begins right after a strobe rise under high voltage
    p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $fell(wr_idle) |-> $past(wstrb_n) && $past(hv_on));

    // R10: data is driven only under read pin conditions
    p_oe_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> prog_mode && !fetch_n && wstrb_n && !hv_on);

    // R10: an undriven bus reads zero
    p_oe_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == 8'h00);

    // R7: lock read uses only bits 2..4
    p_lock_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en && sel == MC_LOCK_RD |-> dout[7:5] == 3'b000 && dout[1:0] == 2'b00);

    // R8: first signature byte
    p_sig0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en && sel == MC_SIG && addr == '0 |-> dout == 8'h1E);

endmodule

bind flashprog_resp flashprog_resp_chk #(
    .ADDR_W       (ADDR_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_mode (prog_mode),
    .fetch_n   (fetch_n),
    .wstrb_n   (wstrb_n),
    .hv_on     (hv_on),
    .sel       (sel),
    .addr      (addr),
    .dout      (dout),
    .dout_en   (dout_en),
    .wr_idle   (wr_idle)
);

// File: tb/flashprog_resp_tb.sv
module flashprog_resp_tb_top;
    import flashprog_pkg::*;

    localparam int AW    = 12;
    localparam int WR    = 20;
    localparam int DEPTH = 1 << AW;
    localparam int ER    = (WR > DEPTH) ? WR : DEPTH;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          prog_mode;
    logic          fetch_n;
    logic          wstrb_n;
    logic          hv_on;
    logic [4:0]    sel;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en;
    logic          wr_idle;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] d;
        logic       oe;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    event smp_ev;

    always #2 clk = ~clk;

    flashprog_resp #(
        .ADDR_W       (AW),
        .WRITE_CYCLES (WR)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_mode (prog_mode),
        .fetch_n   (fetch_n),
        .wstrb_n   (wstrb_n),
        .hv_on     (hv_on),
        .sel       (sel),
        .addr      (addr),
        .din       (din),
        .dout      (dout),
        .dout_en   (dout_en),
        .wr_idle   (wr_idle)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per sample request
    initial begin
        forever begin
            @(smp_ev);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(dout_en == e.oe, {e.tag, " oe"}, dout_en, e.oe);
                if (e.oe) check(dout == e.d, {e.tag, " data"}, dout, e.d);
                else      check(dout == 8'h00, {e.tag, " idle bus"}, dout, 0);
            end
        end
    end

    task automatic drive(input logic pm, input logic fn, input logic ws, input logic hv,
                         input logic [4:0] s, input logic [AW-1:0] a, input logic [7:0] d);
        prog_mode = pm; fetch_n = fn; wstrb_n = ws; hv_on = hv; sel = s; addr = a; din = d;
    endtask

    task automatic push(input logic [7:0] d, input logic oe, input string tag);
        exp_t e;
        e.d = d; e.oe = oe; e.tag = tag;
        sbq.push_back(e);
        -> smp_ev;
    endtask

    task automatic expect_rd(input logic [4:0] s, input logic [AW-1:0] a,
                             input logic [7:0] d, input string tag);
        @(negedge clk);
        drive(1, 0, 1, 0, s, a, 8'h00);
        push(d, 1'b1, tag);
    endtask

    task automatic expect_off(input logic pm, input logic fn, input logic ws, input logic hv,
                              input logic [4:0] s, input string tag);
        @(negedge clk);
        drive(pm, fn, ws, hv, s, 12'h000, 8'h00);
        push(8'h00, 1'b0, tag);
    endtask

    task automatic pulse(input logic pm, input logic fn, input logic hv, input logic [4:0] s,
                         input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); drive(pm, fn, 1, hv, s, a, d);
        @(negedge clk); wstrb_n = 1'b0;
        @(negedge clk); wstrb_n = 1'b1;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        @(negedge clk); #1;
        while (!wr_idle && n < 100000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic run_write(input logic [4:0] s, input logic [AW-1:0] a, input logic [7:0] d,
                             input int exp_len, input string tag);
        int n;
        pulse(1, 0, 1, s, a, d);
        busy_len(n);
        check(n == exp_len, tag, n, exp_len);
    endtask

    task automatic reject(input logic pm, input logic fn, input logic hv, input logic [4:0] s,
                          input string tag);
        int n;
        pulse(pm, fn, hv, s, 12'h300, 8'h00);
        busy_len(n);
        check(n == 0, {tag, " no busy"}, n, 0);
        expect_rd(MC_CODE_RD, 12'h300, 8'hFF, {tag, " byte kept"});
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        drive(0, 1, 1, 0, MC_SIG, 12'h000, 8'h00);
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset
        #1;
        check(wr_idle == 1'b1, "R1 idle after reset", wr_idle, 1);
        check(dout_en == 1'b0, "R1 bus off after reset", dout_en, 0);
        expect_rd(MC_LOCK_RD, 12'h000, 8'h00, "R1 locks clear");

        // R6: erase length and full array contents
        run_write(MC_ERASE, 12'h000, 8'h00, ER, "R6 erase busy length");
        for (int a = 0; a < DEPTH; a++) begin
            expect_rd(MC_CODE_RD, AW'(a), 8'hFF, "R6 erased byte");
        end

        // R9 + R3: poll while a byte write runs, then committed value
        pulse(1, 0, 1, MC_BYTE_WR, 12'h100, 8'hA5);
        for (int i = 1; i <= WR + 1; i++) begin
            @(negedge clk);
            if (i == 2) begin
                drive(1, 0, 1, 0, MC_CODE_RD, 12'h101, 8'h00);
                push(8'hFF, 1'b1, "R9 other address during write");
            end else if (i <= WR) begin
                drive(1, 0, 1, 0, MC_CODE_RD, 12'h100, 8'h00);
                push(8'h25, 1'b1, "R9 polled value");
            end else begin
                drive(1, 0, 1, 0, MC_CODE_RD, 12'h100, 8'h00);
                push(8'hA5, 1'b1, "R3 committed value");
            end
            #1;
            check(wr_idle == (i > WR), "R3 busy window", wr_idle, (i > WR));
        end

        // R3: program only clears bits (A5 & 0F = 05)
        run_write(MC_BYTE_WR, 12'h100, 8'h0F, WR, "R3 byte write length");
        expect_rd(MC_CODE_RD, 12'h100, 8'h05, "R3 AND with stored byte");

        // R5: strobe during busy is dropped
        pulse(1, 0, 1, MC_BYTE_WR, 12'h200, 8'h00);
        n = 0;
        @(negedge clk); drive(1, 0, 0, 1, MC_BYTE_WR, 12'h201, 8'h00);
        #1; if (!wr_idle) n++;
        @(negedge clk); wstrb_n = 1'b1;
        #1; if (!wr_idle) n++;
        forever begin
            @(negedge clk); #1;
            if (wr_idle) break;
            n++;
        end
        check(n == WR, "R5 busy not extended", n, WR);
        expect_rd(MC_CODE_RD, 12'h201, 8'hFF, "R5 dropped write");
        expect_rd(MC_CODE_RD, 12'h200, 8'h00, "R5 first write kept");

        // R4: missing qualifiers or unknown code
        reject(1, 0, 0, MC_BYTE_WR, "R4 no high voltage");
        reject(1, 1, 1, MC_BYTE_WR, "R4 fetch high");
        reject(0, 0, 1, MC_BYTE_WR, "R4 prog mode low");
        reject(1, 0, 1, 5'b01010,   "R4 unknown code");
        reject(1, 0, 1, MC_CODE_RD, "R4 read code with strobe");

        // R7: lock bits
        run_write(MC_LOCK1, 12'h000, 8'h00, WR, "R7 lock1 length");
        expect_rd(MC_LOCK_RD, 12'h000, 8'h04, "R7 lock1 on bit2");
        run_write(MC_LOCK2, 12'h000, 8'h00, WR, "R7 lock2 length");
        expect_rd(MC_LOCK_RD, 12'h000, 8'h0C, "R7 lock2 on bit3");
        run_write(MC_LOCK3, 12'h000, 8'h00, WR, "R7 lock3 length");
        expect_rd(MC_LOCK_RD, 12'h000, 8'h1C, "R7 lock3 on bit4");

        // R8: signatures
        expect_rd(MC_SIG, 12'h000, 8'h1E, "R8 sig 000");
        expect_rd(MC_SIG, 12'h100, 8'h51, "R8 sig 100");
        expect_rd(MC_SIG, 12'h200, 8'h06, "R8 sig 200");
        expect_rd(MC_SIG, 12'h300, 8'h00, "R8 sig other");
        expect_rd(MC_SIG, 12'h001, 8'h00, "R8 sig offset");

        // R2 + R10: bus enable conditions
        expect_off(1, 0, 1, 1, MC_CODE_RD, "R10 high voltage on");
        expect_off(1, 0, 0, 0, MC_CODE_RD, "R10 strobe low");
        expect_off(0, 0, 1, 0, MC_CODE_RD, "R10 prog mode low");
        expect_off(1, 1, 1, 0, MC_CODE_RD, "R10 fetch high");
        expect_off(1, 0, 1, 0, MC_BYTE_WR, "R2 write code not a read");
        expect_off(1, 0, 1, 0, 5'b01010,   "R2 unknown code");

        // R6: second erase clears locks and bytes
        run_write(MC_ERASE, 12'h000, 8'h00, ER, "R6 erase again");
        expect_rd(MC_LOCK_RD, 12'h000, 8'h00, "R6 locks cleared");
        expect_rd(MC_CODE_RD, 12'h100, 8'hFF, "R6 byte restored");
        expect_rd(MC_CODE_RD, 12'h200, 8'hFF, "R6 byte restored 2");

        @(negedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule